// File: doc/BRIEF.md
# Nibble-Packed Tag Memory Controller

This block owns a byte-wide tag store in which every byte carries the 4-bit tags of two neighbouring 16-byte granules. The granule at the lower address uses bits [3:0] and the granule at the higher address uses bits [7:4]. A requester sends one operation at a time: an opcode, a byte address, a 64-bit data word and a flag that says whether the addressed region has tag storage. The block then reads or rewrites tag bytes one per cycle and returns a single response. That response carries either tag data or an alignment fault.

Both the request and the response use valid/ready handshakes. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. It drops once a request is taken and stays low until the response has been taken. That gives each read-modify-write exclusive use of the store. A response is offered with `rsp_valid`. It stays valid, and its fault and data do not change, until a cycle where `rsp_ready` is high. The requester may hold `rsp_ready` low for as long as it likes.

Opcodes are 3 bits: 0 loads one tag, 1 stores one tag, 2 stores one tag into two granules, 3 loads a 64-bit bulk word, 4 stores a 64-bit bulk word, and 5 fills a block with a tag. The tag byte index is the address shifted right by 5, modulo the store depth.

Top module: `tag_nibble_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every tag in the store reads as zero.
- R2: Opcode 0 returns, in `rsp_data[3:0]` with all higher bits zero, the nibble of byte (address >> 5) chosen by address bit 4: bit 4 clear gives bits [3:0], bit 4 set gives bits [7:4]. Address bits [3:0] are ignored.
- R3: Opcode 1 or 2 with address bits [3:0] not all zero returns `rsp_fault` = 1 and changes no tag. This holds whether or not the region is tagged. Opcodes 6 and 7 also return a fault and change nothing.
- R4: Opcode 1 writes `req_data[3:0]` into the nibble chosen by address bit 4 and keeps the other nibble of that byte.
- R5: Opcode 2 with address bit 4 clear writes the tag into both nibbles of byte (address >> 5).
- R6: Opcode 2 with address bit 4 set writes the tag into bits [7:4] of byte i and bits [3:0] of byte i+1, where i is the byte index, taken modulo the store depth. The other nibble of each of the two bytes is kept.
- R7: Opcode 3 aligns the address down to 256 bytes and returns the 8 tag bytes of that region with the lowest-addressed byte in bits [7:0]. Loads (opcodes 0 and 3) never fault.
- R8: Opcode 4 aligns the address down to 256 bytes and writes `req_data` into the region's 8 tag bytes, with bits [7:0] going to the lowest-addressed byte.
- R9: Opcode 5 aligns the address down to 2^ZB_LOG2 bytes (at least 32) and writes `req_data[3:0]` × 0x11 into every tag byte of that block. Bytes outside the block keep their values.
- R10: With `req_tagged` = 0, loads return zero data and stores change no tag. No fault is raised unless R3 applies.
- R11: `req_ready` is low from the acceptance of a request until its response is taken. `rsp_valid`, `rsp_fault` and `rsp_data` hold steady while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 64 | Tag in bits [3:0], or bulk word |
| req_tagged | input | 1 | Region has tag storage |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Alignment fault or unknown opcode |
| rsp_data | output | 64 | Loaded tag or bulk word, zero for stores |

## Verification
The properties assume a requester that obeys the handshake. Such a requester never expects a second request to be taken while a response is still waiting. It treats `req_tagged` as a property of the request it comes with. Under those assumptions the tagged flag latched with an operation governs every write of that operation. The stimulus keeps to this by issuing one request at a time, waiting for each response, and dropping `req_valid` once the request has been taken. For the response-hold test it keeps `rsp_ready` low for several cycles on purpose. Stimulus addresses include misaligned, top-of-store and unaligned bulk cases. This exercises the wrap-around of two-granule stores and the align-down of bulk and fill operations.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam logic [2:0] OP_LDT    = 3'd0;
  localparam logic [2:0] OP_STT    = 3'd1;
  localparam logic [2:0] OP_ST2T   = 3'd2;
  localparam logic [2:0] OP_LDBULK = 3'd3;
  localparam logic [2:0] OP_STBULK = 3'd4;
  localparam logic [2:0] OP_ZFILL  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RESP} tmc_state_e;

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_STT) || (op == OP_ST2T) || (op == OP_STBULK) || (op == OP_ZFILL);
  endfunction
endpackage

// File: rtl/tmc_ram.sv
module tmc_ram #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  assign rbyte = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wbyte;
    end
  end
endmodule

// File: rtl/tmc_merge.sv
module tmc_merge
  import tmc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int ZB_LOG2 = 6,
  parameter int CNT_W   = 3
) (
  input  logic              run,
  input  logic [2:0]        op,
  input  logic [ADDR_W-5:0] gaddr,   // address bits [ADDR_W-1:4]
  input  logic [63:0]       data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [7:0]        rbyte,
  output logic [ADDR_W-6:0] idx,
  output logic              we,
  output logic [7:0]        wbyte
);
  localparam int IDX_W    = ADDR_W - 5;
  localparam int ZB_BYTES = 1 << (ZB_LOG2 - 5);
  localparam logic [IDX_W-1:0] BULK_MASK = ~IDX_W'(7);
  localparam logic [IDX_W-1:0] FILL_MASK = ~IDX_W'(ZB_BYTES - 1);

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] mask;
  logic             hi;
  logic [3:0]       tag;

  assign base = gaddr[ADDR_W-5:1];
  assign hi   = gaddr[0];
  assign tag  = data[3:0];

  always_comb begin
    case (op)
      OP_LDBULK, OP_STBULK: mask = BULK_MASK;
      OP_ZFILL:             mask = FILL_MASK;
      default:              mask = '1;
    endcase
    idx = (base & mask) + IDX_W'(cnt);
  end

  always_comb begin
    case (op)
      OP_STT:    wbyte = hi ? {tag, rbyte[3:0]} : {rbyte[7:4], tag};
      OP_ST2T: begin
        if (!hi)           wbyte = {tag, tag};
        else if (cnt == 0) wbyte = {tag, rbyte[3:0]};
        else               wbyte = {rbyte[7:4], tag};
      end
      OP_STBULK: wbyte = data[{cnt[2:0], 3'b000} +: 8];
      OP_ZFILL:  wbyte = {tag, tag};
      default:   wbyte = rbyte;
    endcase
    we = run && op_writes(op);
  end
endmodule

// File: rtl/tmc_ctrl.sv
module tmc_ctrl
  import tmc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int ZB_LOG2 = 6,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic              req_tagged,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [63:0]       rsp_data,
  input  logic [7:0]        rbyte,
  output logic              run,
  output logic [2:0]        op_q,
  output logic [ADDR_W-5:0] gaddr_q,
  output logic [63:0]       data_q,
  output logic              tagged_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam int ZB_BYTES = 1 << (ZB_LOG2 - 5);

  tmc_state_e       state;
  logic             fault_q;
  logic [63:0]      res_q;
  logic             bad;
  logic [CNT_W-1:0] last;

  assign bad = (((req_op == OP_STT) || (req_op == OP_ST2T)) && (req_addr[3:0] != 4'd0))
             || (req_op > OP_ZFILL);

  always_comb begin
    case (op_q)
      OP_ST2T:             last = gaddr_q[0] ? CNT_W'(1) : '0;
      OP_LDBULK, OP_STBULK: last = CNT_W'(7);
      OP_ZFILL:            last = CNT_W'(ZB_BYTES - 1);
      default:             last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      gaddr_q  <= '0;
      data_q   <= '0;
      tagged_q <= 1'b0;
      cnt_q    <= '0;
      fault_q  <= 1'b0;
      res_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q     <= req_op;
          gaddr_q  <= req_addr[ADDR_W-1:4];
          data_q   <= req_data;
          tagged_q <= req_tagged;
          cnt_q    <= '0;
          res_q    <= '0;
          fault_q  <= bad;
          state    <= (bad || !req_tagged) ? S_RESP : S_RUN;
        end
        S_RUN: begin
          if (op_q == OP_LDT)
            res_q[3:0] <= gaddr_q[0] ? rbyte[7:4] : rbyte[3:0];
          else if (op_q == OP_LDBULK)
            res_q[{cnt_q[2:0], 3'b000} +: 8] <= rbyte;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last) state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign run       = (state == S_RUN);
  assign rsp_fault = fault_q;
  assign rsp_data  = res_q;
endmodule

// File: rtl/tag_nibble_ctrl.sv
module tag_nibble_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int ZB_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic              req_tagged,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [63:0]       rsp_data
);
  localparam int IDX_W    = ADDR_W - 5;
  localparam int ZB_BYTES = 1 << (ZB_LOG2 - 5);
  localparam int MAXN     = (ZB_BYTES > 8) ? ZB_BYTES : 8;
  localparam int CNT_W    = $clog2(MAXN);

  logic              run;
  logic [2:0]        cur_op;
  logic [ADDR_W-5:0] cur_gaddr;
  logic [63:0]       cur_data;
  logic              cur_tagged;
  logic [CNT_W-1:0]  cur_cnt;
  logic [IDX_W-1:0]  ram_idx;
  logic              ram_we;
  logic [7:0]        ram_wbyte;
  logic [7:0]        ram_rbyte;

  tmc_ctrl #(.ADDR_W(ADDR_W), .ZB_LOG2(ZB_LOG2), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_tagged(req_tagged),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data), .rbyte(ram_rbyte), .run(run), .op_q(cur_op),
    .gaddr_q(cur_gaddr), .data_q(cur_data), .tagged_q(cur_tagged), .cnt_q(cur_cnt)
  );

  tmc_merge #(.ADDR_W(ADDR_W), .ZB_LOG2(ZB_LOG2), .CNT_W(CNT_W)) u_merge (
    .run(run), .op(cur_op), .gaddr(cur_gaddr), .data(cur_data), .cnt(cur_cnt),
    .rbyte(ram_rbyte), .idx(ram_idx), .we(ram_we), .wbyte(ram_wbyte)
  );

  tmc_ram #(.IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
    .wbyte(ram_wbyte), .rbyte(ram_rbyte)
  );
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
  import tmc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [63:0]       rsp_data,
  input logic [2:0]        op_q,
  input logic              tagged_q,
  input logic              ram_we
);
  a_r11_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_fault));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && (op_q == OP_LDT) |-> (rsp_data[63:4] == 60'd0));

  a_r7_load_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && ((op_q == OP_LDT) || (op_q == OP_LDBULK)) |-> !rsp_fault);

  a_r10_untagged_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !tagged_q |-> !ram_we);

  a_r3_misaligned_fault: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ((req_op == OP_STT) || (req_op == OP_ST2T)) && (req_addr[3:0] != 4'd0)
    |=> rsp_valid && rsp_fault && !ram_we);
endmodule

bind tag_nibble_ctrl tmc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
  .op_q(cur_op), .tagged_q(cur_tagged), .ram_we(ram_we)
);

// File: tb/sim_tag_nibble_ctrl.sv
`timescale 1ns/1ps
module sim_tag_nibble_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic        req_tagged = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [63:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tag_nibble_ctrl #(.ADDR_W(12), .ZB_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_tagged(req_tagged), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op;
    logic [11:0] addr;
    logic [63:0] data;
    logic        tg;
    logic        flt;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 36;
  // requirement number, opcode, address, data, tagged, expected fault, expected data
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'd0, 12'h000, 64'h0, 1'b1, 1'b0, 64'h0},                 // R1 zero after reset
    '{4'd4,  3'd1, 12'h040, 64'h5, 1'b1, 1'b0, 64'h0},                 // R4
    '{4'd4,  3'd1, 12'h050, 64'hA, 1'b1, 1'b0, 64'h0},                 // R4
    '{4'd2,  3'd0, 12'h040, 64'h0, 1'b1, 1'b0, 64'h5},                 // R2 low nibble
    '{4'd2,  3'd0, 12'h05F, 64'h0, 1'b1, 1'b0, 64'hA},                 // R2 high nibble, low bits ignored
    '{4'd3,  3'd1, 12'h044, 64'h3, 1'b1, 1'b1, 64'h0},                 // R3 misaligned
    '{4'd3,  3'd0, 12'h040, 64'h0, 1'b1, 1'b0, 64'h5},                 // R3 unchanged
    '{4'd4,  3'd1, 12'h040, 64'h7, 1'b1, 1'b0, 64'h0},                 // R4
    '{4'd4,  3'd0, 12'h050, 64'h0, 1'b1, 1'b0, 64'hA},                 // R4 other nibble kept
    '{4'd5,  3'd2, 12'h080, 64'h9, 1'b1, 1'b0, 64'h0},                 // R5
    '{4'd5,  3'd0, 12'h090, 64'h0, 1'b1, 1'b0, 64'h9},                 // R5
    '{4'd5,  3'd0, 12'h080, 64'h0, 1'b1, 1'b0, 64'h9},                 // R5
    '{4'd6,  3'd2, 12'h0B0, 64'hC, 1'b1, 1'b0, 64'h0},                 // R6 straddle
    '{4'd7,  3'd3, 12'h0F3, 64'h0, 1'b1, 1'b0, 64'h000CC09900A70000},  // R7 align-down, R6 result
    '{4'd8,  3'd4, 12'h155, 64'h0123456789ABCDEF, 1'b1, 1'b0, 64'h0},  // R8
    '{4'd7,  3'd3, 12'h100, 64'h0, 1'b1, 1'b0, 64'h0123456789ABCDEF},  // R7
    '{4'd8,  3'd0, 12'h120, 64'h0, 1'b1, 1'b0, 64'hD},                 // R8 byte order
    '{4'd8,  3'd0, 12'h130, 64'h0, 1'b1, 1'b0, 64'hC},                 // R8 byte order
    '{4'd9,  3'd5, 12'h13F, 64'hF6, 1'b1, 1'b0, 64'h0},                // R9 fill
    '{4'd9,  3'd3, 12'h100, 64'h0, 1'b1, 1'b0, 64'h0123456789AB6666},  // R9 block only
    '{4'd10, 3'd1, 12'h040, 64'h1, 1'b0, 1'b0, 64'h0},                 // R10 dropped store
    '{4'd10, 3'd0, 12'h040, 64'h0, 1'b0, 1'b0, 64'h0},                 // R10 zero load
    '{4'd10, 3'd0, 12'h040, 64'h0, 1'b1, 1'b0, 64'h7},                 // R10 memory kept
    '{4'd10, 3'd4, 12'h100, 64'h0, 1'b0, 1'b0, 64'h0},                 // R10 dropped bulk
    '{4'd10, 3'd3, 12'h100, 64'h0, 1'b0, 1'b0, 64'h0},                 // R10 zero bulk load
    '{4'd10, 3'd3, 12'h100, 64'h0, 1'b1, 1'b0, 64'h0123456789AB6666},  // R10 memory kept
    '{4'd3,  3'd6, 12'h000, 64'h5, 1'b1, 1'b1, 64'h0},                 // R3 opcode 6
    '{4'd3,  3'd7, 12'h000, 64'h5, 1'b1, 1'b1, 64'h0},                 // R3 opcode 7
    '{4'd3,  3'd1, 12'h041, 64'h2, 1'b0, 1'b1, 64'h0},                 // R3 fault when untagged
    '{4'd3,  3'd2, 12'h088, 64'h0, 1'b1, 1'b1, 64'h0},                 // R3 two-granule misaligned
    '{4'd3,  3'd0, 12'h080, 64'h0, 1'b1, 1'b0, 64'h9},                 // R3 unchanged
    '{4'd6,  3'd2, 12'hFF0, 64'hE, 1'b1, 1'b0, 64'h0},                 // R6 wrap at top
    '{4'd6,  3'd0, 12'hFF0, 64'h0, 1'b1, 1'b0, 64'hE},                 // R6
    '{4'd6,  3'd0, 12'hFE0, 64'h0, 1'b1, 1'b0, 64'h0},                 // R6 kept nibble
    '{4'd6,  3'd0, 12'h000, 64'h0, 1'b1, 1'b0, 64'hE},                 // R6 wrapped byte
    '{4'd6,  3'd0, 12'h010, 64'h0, 1'b1, 1'b0, 64'h0}                  // R6 kept nibble
  };

  task automatic check(input int rq, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [11:0] a, input logic [63:0] d,
                       input logic tg, output logic f, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tagged = tg;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    f = rsp_fault;
    r = rsp_data;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic        f;
    logic [63:0] r;
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(1, {63'd0, req_ready}, 64'd1, "req_ready after reset");   // R1
    check(1, {63'd0, rsp_valid}, 64'd0, "rsp_valid after reset");   // R1

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].tg, f, r);
      check(int'(VEC[i].rq), {63'd0, f}, {63'd0, VEC[i].flt}, $sformatf("vector %0d fault", i));
      check(int'(VEC[i].rq), r, VEC[i].exp, $sformatf("vector %0d data", i));
    end

    // R11: response held under back-pressure, requests blocked meanwhile
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 3'd3; req_addr = 12'h100; req_data = '0; req_tagged = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    check(11, held, 64'h0123456789AB6666, "bulk load under back-pressure");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(11, {62'd0, rsp_valid, req_ready}, 64'd2, "valid held, ready low");
      check(11, rsp_data, held, "data held");
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    check(11, {63'd0, req_ready}, 64'd1, "ready after response taken");

    // R1: reset again clears the store
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    issue(3'd0, 12'h080, 64'h0, 1'b1, f, r);
    check(1, r, 64'h0, "tag cleared by reset");
    issue(3'd3, 12'h100, 64'h0, 1'b1, f, r);
    check(1, r, 64'h0, "bulk cleared by reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule